// File: doc/BRIEF.md
# Byte-Wide Serial Peripheral Controller with Fault Flags

This block is an 8-bit serial peripheral interface unit that a small processor controls through three byte registers. As a master it produces the serial clock itself, at the system clock divided by a fixed even factor. As a slave it follows an external clock and select line, which it first brings into the system clock domain through a synchroniser. Bytes move most significant bit first in clock mode 0: data changes after a falling edge and is sampled on a rising edge.

Three faults are detected. The first is a second master pulling the select line low while this unit is master, which shuts the unit down. The second is a write to the data register while a byte is in flight, which is discarded and flagged. The third is the select line of a slave rising before a whole byte has arrived. Each fault flag has its own clearing sequence. Two interrupt requests are provided: one for a finished byte, and one for the mode fault, which is gated by the select-ignore bit. Overrun is not detected. While the finished flag is pending, later bytes are dropped and the first byte received is kept.

Top module: `spi_fault_ctrl`

## Requirements
- R1: When the unit is enabled as master (control address 0, bit 0 enable, bit 1 master) and idle, a write to data address 2 sends that byte on `mosi_o`, most significant bit first. `mosi_o` changes after falling `sck_o` edges, and the rising `sck_o` edges are DIV system clocks apart (4 by default). The byte sampled from `miso_i` is then read back at address 2.
- R2: In master mode with control bit 2 (select-ignore) clear, a low `ss_n_i` sets status bit 4 (address 1), clears the enable and master bits, and raises `irq_err`.
- R3: With select-ignore set, a low `ss_n_i` sets no mode fault, and the control bits keep their values.
- R4: The mode fault flag clears only on a control write that comes after a status read in which the flag was seen set. A control write alone leaves it set. The clearing write may set enable and master again.
- R5: A data write while a byte is in flight sets status bit 6 (collision) and raises no interrupt. The byte in flight completes unchanged, and the value written is discarded.
- R6: The collision flag clears on a data register access that comes after a status read in which it was seen set. A data access alone leaves it set.
- R7: In slave mode (enable set, master clear), if `ss_n_i` rises after at least one bit of a byte has been received and before the byte is complete, status bit 5 is set. No interrupt is raised.
- R8: Status bit 5 clears only on a control write with bit 0 equal to 0. A control write with bit 0 equal to 1 leaves it set. After it is cleared, the next full slave byte completes normally.
- R9: `irq_xfer` follows the finished flag, which is status bit 7. `irq_err` is the mode fault flag gated off by select-ignore: setting select-ignore while a fault is pending drops `irq_err`, and the flag stays set.
- R10: A byte that completes while the finished flag is still set is not stored. The data read returns the first byte received since the flag was last cleared.
- R11: The finished flag clears on a data access that comes after a status read in which it was seen set. A data access alone leaves it set.
- R12: After reset, all control bits, flags and the received byte are 0. While enable is 0, `sck_o`, `mosi_o` and `miso_o` stay low, and a data write starts no transfer.
- R13: In slave mode with `ss_n_i` low, the unit shifts out on `miso_o` the byte last written to address 2, most significant bit first. It captures `mosi_i` on rising `sck_i` edges and sets the finished flag after 8 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; side effects happen on this cycle |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data of the selected register |
| sck_o | output | 1 | Serial clock driven in master mode |
| mosi_o | output | 1 | Serial data out in master mode |
| miso_i | input | 1 | Serial data in in master mode |
| sck_i | input | 1 | Serial clock in slave mode |
| mosi_i | input | 1 | Serial data in in slave mode |
| ss_n_i | input | 1 | Active-low select (slave select, or fault sense in master mode) |
| miso_o | output | 1 | Serial data out in slave mode |
| irq_xfer | output | 1 | Byte-finished interrupt request |
| irq_err | output | 1 | Mode-fault interrupt request |

## Verification
A wrong bit counter or divider shows at the bench slave model as a wrong byte or a wrong rising-edge spacing, within one byte time of about 8×DIV cycles. A wrong arm bit behind a flag shows as a flag that clears too early or never clears. This is visible at the status read that follows the clearing access, and on `irq_xfer` or `irq_err` in the next cycle. Wrong mode-fault handling shows on `irq_err` and in the control read-back within the synchroniser depth plus one cycle after `ss_n_i` falls. A wrong overrun rule shows as the wrong byte at the next data read.

// File: rtl/spi_fc_pkg.sv
package spi_fc_pkg;
   typedef enum logic [1:0] {
      RA_CTRL = 2'd0,
      RA_STAT = 2'd1,
      RA_DATA = 2'd2
   } reg_addr_e;

   // control register bit positions
   localparam int CB_EN    = 0;
   localparam int CB_MSTR  = 1;
   localparam int CB_SSDIS = 2;

   // status register bit positions
   localparam int SB_DONE  = 7;
   localparam int SB_COL   = 6;
   localparam int SB_SSERR = 5;
   localparam int SB_FAULT = 4;

   // index of each read-then-access flag inside the paired flag bank
   localparam int FI_DONE  = 0;
   localparam int FI_COL   = 1;
   localparam int FI_FAULT = 2;
   localparam int FI_NUM   = 3;
endpackage

// File: rtl/spi_fc_sync.sv
module spi_fc_sync #(
   parameter int            W      = 3,
   parameter int            STAGES = 2,
   parameter logic [W-1:0]  RST    = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES == 1) begin : g_one
         logic [W-1:0] st;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st <= RST;
            else        st <= d;
         end
         assign q = st;
      end else begin : g_chain
         logic [STAGES-1:0][W-1:0] st;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st <= {STAGES{RST}};
            else        st <= {st[STAGES-2:0], d};
         end
         assign q = st[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/spi_fc_engine.sv
module spi_fc_engine #(
   parameter int DW  = 8,
   parameter int DIV = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          mstr,
   input  logic          ss_sel_n,
   input  logic          start,
   input  logic [DW-1:0] load_byte,
   input  logic [DW-1:0] txbuf,
   input  logic          miso_i,
   input  logic          sck_s,
   input  logic          mosi_s,
   output logic          sck_o,
   output logic          mosi_o,
   output logic          miso_o,
   output logic          busy,
   output logic          done,
   output logic [DW-1:0] rx_byte,
   output logic          ss_abort
);
   localparam int HALF = DIV / 2;
   localparam int CW   = (DW > 1) ? $clog2(DW) : 1;
   localparam int DCW  = (DIV > 1) ? $clog2(DIV) : 1;

   logic [DW-1:0]  sreg, rx_q;
   logic [CW-1:0]  bitcnt;
   logic [DCW-1:0] divcnt;
   logic           smp, mbusy, sck_q, reload, done_q, abort_q;
   logic           master_on, slave_on, sel, rise, fall, last_bit;

   assign master_on = en && mstr;
   assign slave_on  = en && !mstr;
   assign sel       = slave_on && !ss_sel_n;
   assign rise      = sck_s && !sck_q;
   assign fall      = !sck_s && sck_q;
   assign last_bit  = (bitcnt == CW'(DW - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg <= '0; rx_q <= '0; bitcnt <= '0; divcnt <= '0;
         smp <= 1'b0; mbusy <= 1'b0; sck_q <= 1'b0; reload <= 1'b0;
         done_q <= 1'b0; abort_q <= 1'b0;
      end else begin
         done_q  <= 1'b0;
         abort_q <= 1'b0;
         sck_q   <= sck_s;
         if (master_on) begin
            reload <= 1'b0;
            if (!mbusy) begin
               divcnt <= '0;
               bitcnt <= '0;
               if (start) begin
                  sreg  <= load_byte;
                  mbusy <= 1'b1;
               end
            end else begin
               divcnt <= (divcnt == DCW'(DIV - 1)) ? '0 : divcnt + DCW'(1);
               if (divcnt == DCW'(HALF - 1)) smp <= miso_i;
               if (divcnt == DCW'(DIV - 1)) begin
                  sreg   <= {sreg[DW-2:0], smp};
                  bitcnt <= bitcnt + CW'(1);
                  if (last_bit) begin
                     mbusy  <= 1'b0;
                     done_q <= 1'b1;
                     rx_q   <= {sreg[DW-2:0], smp};
                  end
               end
            end
         end else begin
            mbusy  <= 1'b0;
            divcnt <= '0;
            if (!sel) begin
               if (slave_on && bitcnt != '0 && !mbusy) abort_q <= 1'b1;
               bitcnt <= '0;
               reload <= 1'b0;
               sreg   <= txbuf;
            end else begin
               if (rise) begin
                  smp <= mosi_s;
                  if (last_bit) begin
                     bitcnt <= '0;
                     done_q <= 1'b1;
                     rx_q   <= {sreg[DW-2:0], mosi_s};
                     reload <= 1'b1;
                  end else begin
                     bitcnt <= bitcnt + CW'(1);
                  end
               end
               if (fall) begin
                  if (reload) begin
                     sreg   <= txbuf;
                     reload <= 1'b0;
                  end else begin
                     sreg <= {sreg[DW-2:0], smp};
                  end
               end
            end
         end
      end
   end

   assign sck_o    = mbusy && (divcnt >= DCW'(HALF));
   assign mosi_o   = master_on && mbusy && sreg[DW-1];
   assign miso_o   = sel && sreg[DW-1];
   assign busy     = master_on ? mbusy : (sel && bitcnt != '0);
   assign done     = done_q;
   assign rx_byte  = rx_q;
   assign ss_abort = abort_q;
endmodule

// File: rtl/spi_fc_flags.sv
module spi_fc_flags #(
   parameter int NP = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NP-1:0] set_v,
   input  logic [NP-1:0] clr_v,
   input  logic          stat_rd,
   output logic [NP-1:0] flag_v
);
   generate
      for (genvar i = 0; i < NP; i++) begin : g_flag
         logic f, arm;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               f   <= 1'b0;
               arm <= 1'b0;
            end else begin
               // a new event wins over a clear in the same cycle
               if (set_v[i])               f <= 1'b1;
               else if (arm && clr_v[i])   f <= 1'b0;
               // arm only when software has seen the flag set
               if (arm && clr_v[i])        arm <= 1'b0;
               else if (stat_rd && f)      arm <= 1'b1;
            end
         end
         assign flag_v[i] = f;
      end
   endgenerate
endmodule

// File: rtl/spi_fault_ctrl.sv
module spi_fault_ctrl #(
   parameter int DW   = 8,
   parameter int DIV  = 4,
   parameter int SYNC = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    reg_addr,
   input  logic          reg_wr,
   input  logic          reg_rd,
   input  logic [DW-1:0] reg_wdata,
   output logic [DW-1:0] reg_rdata,
   output logic          sck_o,
   output logic          mosi_o,
   input  logic          miso_i,
   input  logic          sck_i,
   input  logic          mosi_i,
   input  logic          ss_n_i,
   output logic          miso_o,
   output logic          irq_xfer,
   output logic          irq_err
);
   import spi_fc_pkg::*;

   generate
      if (DW < 8) begin : g_bad_dw
         $error("spi_fault_ctrl: DW must be at least 8");
      end
      if (DIV < 2 || (DIV % 2) != 0) begin : g_bad_div
         $error("spi_fault_ctrl: DIV must be even and at least 2");
      end
      if (SYNC < 1) begin : g_bad_sync
         $error("spi_fault_ctrl: SYNC must be at least 1");
      end
   endgenerate

   logic              acc_ctrl_wr, acc_stat_rd, acc_data, acc_data_wr;
   logic              ctl_en, ctl_mstr, ctl_ssdis;
   logic              sck_s, mosi_s, ss_s;
   logic              fault_evt, col_set, start;
   logic              eng_busy, eng_done, eng_abort;
   logic [DW-1:0]     eng_rx, txbuf, rx_hold;
   logic [FI_NUM-1:0] pset, pclr, pflag;
   logic              flg_done, flg_col, flg_fault, flg_sserr;

   assign acc_ctrl_wr = reg_wr && (reg_addr == RA_CTRL);
   assign acc_stat_rd = reg_rd && (reg_addr == RA_STAT);
   assign acc_data    = (reg_wr || reg_rd) && (reg_addr == RA_DATA);
   assign acc_data_wr = reg_wr && (reg_addr == RA_DATA);

   spi_fc_sync #(.W(3), .STAGES(SYNC), .RST(3'b001)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d({sck_i, mosi_i, ss_n_i}),
      .q({sck_s, mosi_s, ss_s})
   );

   assign fault_evt = ctl_en && ctl_mstr && !ctl_ssdis && !ss_s;
   assign col_set   = acc_data_wr && eng_busy;
   assign start     = acc_data_wr && !eng_busy && ctl_en && ctl_mstr && !fault_evt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_en <= 1'b0; ctl_mstr <= 1'b0; ctl_ssdis <= 1'b0;
         txbuf <= '0; rx_hold <= '0; flg_sserr <= 1'b0;
      end else begin
         if (acc_ctrl_wr) begin
            ctl_en    <= reg_wdata[CB_EN];
            ctl_mstr  <= reg_wdata[CB_MSTR];
            ctl_ssdis <= reg_wdata[CB_SSDIS];
         end
         if (fault_evt) begin
            ctl_en   <= 1'b0;
            ctl_mstr <= 1'b0;
         end
         if (acc_data_wr && !eng_busy) txbuf <= reg_wdata;
         if (eng_done && !flg_done)    rx_hold <= eng_rx;
         if (eng_abort)                              flg_sserr <= 1'b1;
         else if (acc_ctrl_wr && !reg_wdata[CB_EN])  flg_sserr <= 1'b0;
      end
   end

   spi_fc_engine #(.DW(DW), .DIV(DIV)) u_eng (
      .clk(clk), .rst_n(rst_n), .en(ctl_en), .mstr(ctl_mstr),
      .ss_sel_n(ss_s && !ctl_ssdis), .start(start),
      .load_byte(reg_wdata), .txbuf(txbuf), .miso_i(miso_i),
      .sck_s(sck_s), .mosi_s(mosi_s), .sck_o(sck_o), .mosi_o(mosi_o),
      .miso_o(miso_o), .busy(eng_busy), .done(eng_done),
      .rx_byte(eng_rx), .ss_abort(eng_abort)
   );

   always_comb begin
      pset = '0;
      pclr = '0;
      pset[FI_DONE]  = eng_done;
      pclr[FI_DONE]  = acc_data;
      pset[FI_COL]   = col_set;
      pclr[FI_COL]   = acc_data;
      pset[FI_FAULT] = fault_evt;
      pclr[FI_FAULT] = acc_ctrl_wr;
   end

   spi_fc_flags #(.NP(FI_NUM)) u_flags (
      .clk(clk), .rst_n(rst_n), .set_v(pset), .clr_v(pclr),
      .stat_rd(acc_stat_rd), .flag_v(pflag)
   );

   assign flg_done  = pflag[FI_DONE];
   assign flg_col   = pflag[FI_COL];
   assign flg_fault = pflag[FI_FAULT];

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         RA_CTRL: begin
            reg_rdata[CB_EN]    = ctl_en;
            reg_rdata[CB_MSTR]  = ctl_mstr;
            reg_rdata[CB_SSDIS] = ctl_ssdis;
         end
         RA_STAT: begin
            reg_rdata[SB_DONE]  = flg_done;
            reg_rdata[SB_COL]   = flg_col;
            reg_rdata[SB_SSERR] = flg_sserr;
            reg_rdata[SB_FAULT] = flg_fault;
         end
         RA_DATA: reg_rdata = rx_hold;
         default: reg_rdata = '0;
      endcase
   end

   assign irq_xfer = flg_done;
   assign irq_err  = flg_fault && !ctl_ssdis;
endmodule

// File: rtl/spi_fc_chk.sv
module spi_fc_chk #(
   parameter int DW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          ctl_en,
   input logic          ctl_mstr,
   input logic          ctl_ssdis,
   input logic          flg_done,
   input logic          flg_col,
   input logic          flg_sserr,
   input logic          flg_fault,
   input logic          acc_ctrl_wr,
   input logic          acc_data,
   input logic          eng_done,
   input logic [DW-1:0] rx_hold,
   input logic          sck_o,
   input logic          mosi_o,
   input logic          miso_o,
   input logic          irq_xfer
);
   AST_FAULT_SHUTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flg_fault) |-> !ctl_en && !ctl_mstr); // R2
   AST_SS_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_ssdis && $past(ctl_ssdis) |-> !$rose(flg_fault)); // R3
   AST_FAULT_CLEAR_PATH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flg_fault) |-> $past(acc_ctrl_wr)); // R4
   AST_COL_CLEAR_PATH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flg_col) |-> $past(acc_data)); // R6
   AST_SSERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flg_sserr) |-> !ctl_en); // R8
   AST_XFER_IRQ_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_xfer) |-> $past(eng_done)); // R9
   AST_OVERRUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      flg_done && $past(flg_done) |-> $stable(rx_hold)); // R10
   AST_DONE_CLEAR_PATH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flg_done) |-> $past(acc_data)); // R11
   AST_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_en && $past(!ctl_en) |-> !sck_o && !mosi_o && !miso_o); // R12
endmodule

bind spi_fault_ctrl spi_fc_chk #(.DW(DW)) u_chk (.*);

// File: tb/sim_spi_fault_ctrl.sv
module sim_spi_fault_ctrl;
   // 100 MHz: one clock period is 10 delay units
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] reg_addr = 2'd0;
   logic       reg_wr = 1'b0, reg_rd = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       sck_o, mosi_o, miso_i, miso_o, irq_xfer, irq_err;
   logic       sck_i = 1'b0, mosi_i = 1'b0, ss_n_i = 1'b1;

   int checks = 0, errors = 0, cyc = 0;
   int sck_rises = 0, sck_last = 0, sck_prev = 0;
   int bs_falls = 0, bs_base = 0;
   logic [7:0] bs_tx = 8'h00, bs_rx = 8'h00;

   always #5 clk = ~clk;

   spi_fault_ctrl #(.DW(8), .DIV(4), .SYNC(2)) u0 (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .sck_o(sck_o), .mosi_o(mosi_o), .miso_i(miso_i), .sck_i(sck_i),
      .mosi_i(mosi_i), .ss_n_i(ss_n_i), .miso_o(miso_o),
      .irq_xfer(irq_xfer), .irq_err(irq_err)
   );

   // bench slave for master tests: mode 0, returns bs_tx
   assign miso_i = bs_tx[3'(7 - (bs_falls - bs_base))];
   always @(posedge sck_o) begin
      bs_rx = {bs_rx[6:0], mosi_o};
      sck_prev = sck_last;
      sck_last = cyc;
      sck_rises++;
   end
   always @(negedge sck_o) bs_falls++;

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         errors++;
         $display("FAIL watchdog expired got %0d exp <150000", cyc);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %h exp %h", tag, got, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_rd = 1'b1;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic wait_xfer(input string tag);
      int n = 0;
      while (!irq_xfer && n < 300) begin
         @(negedge clk);
         n++;
      end
      chk(tag, 32'(irq_xfer), 32'd1);
   endtask

   task automatic master_byte(input logic [7:0] tx, input logic [7:0] ret);
      bs_tx = ret;
      bs_base = bs_falls;
      wr(2'd2, tx);
   endtask

   // bench master for slave tests, half period of 6 clocks
   task automatic slave_xfer(input logic [7:0] m, input int nbits, output logic [7:0] got);
      got = 8'h00;
      ss_n_i = 1'b0;
      idle(6);
      for (int i = 0; i < nbits; i++) begin
         mosi_i = m[7 - i];
         idle(6);
         got = {got[6:0], miso_o};
         sck_i = 1'b1;
         idle(6);
         sck_i = 1'b0;
      end
      idle(6);
      ss_n_i = 1'b1;
      idle(6);
   endtask

   initial begin
      logic [7:0] v, got, tx, ret, m;
      int r0;
      idle(3);
      rst_n = 1'b1;
      idle(2);

      // R12 reset state
      rd(2'd0, v); chk("R12 ctrl after reset", 32'(v), 32'h00);
      rd(2'd1, v); chk("R12 status after reset", 32'(v), 32'h00);
      rd(2'd2, v); chk("R12 data after reset", 32'(v), 32'h00);
      chk("R12 pins idle after reset", {28'd0, sck_o, mosi_o, miso_o, irq_xfer | irq_err}, 32'd0);
      r0 = sck_rises;
      wr(2'd2, 8'h5A);
      idle(40);
      chk("R12 no clock while disabled", 32'(sck_rises - r0), 32'd0);
      rd(2'd1, v); chk("R12 no flag while disabled", 32'(v), 32'h00);

      // R1 master sweep, select-ignore set
      wr(2'd0, 8'h07);
      for (int i = 0; i < 18; i++) begin
         tx  = (i == 16) ? 8'h00 : (i == 17) ? 8'hFF : 8'((i * 29 + 3) & 255);
         ret = (i == 16) ? 8'hFF : (i == 17) ? 8'h00 : 8'(((i * 71) ^ 8'hA5) & 255);
         master_byte(tx, ret);
         wait_xfer("R1 master byte finishes");
         chk("R1 byte seen by slave msb first", 32'(bs_rx), 32'(tx));
         chk("R1 sck rising spacing is DIV", 32'(sck_last - sck_prev), 32'd4);
         if (i == 0) begin
            rd(2'd2, v);
            chk("R11 data read alone keeps flag", 32'(irq_xfer), 32'd1);
         end
         rd(2'd1, v); chk("R9 status shows finished", 32'(v), 32'h80);
         rd(2'd2, v); chk("R1 received byte", 32'(v), 32'(ret));
         chk("R11 flag cleared by status then data", 32'(irq_xfer), 32'd0);
      end

      // R10 overrun: second byte dropped
      master_byte(8'hA0, 8'h11);
      wait_xfer("R10 first byte");
      master_byte(8'hB0, 8'h22);
      idle(60);
      chk("R10 second byte still sent", 32'(bs_rx), 32'hB0);
      rd(2'd1, v); chk("R10 only finished flag", 32'(v), 32'h80);
      rd(2'd2, v); chk("R10 first byte kept", 32'(v), 32'h11);

      // R5 / R6 write collision
      master_byte(8'h96, 8'h3C);
      idle(8);
      wr(2'd2, 8'h69);
      chk("R5 collision raises no error request", 32'(irq_err), 32'd0);
      wait_xfer("R5 transfer continues");
      chk("R5 byte in flight unchanged", 32'(bs_rx), 32'h96);
      rd(2'd2, v); chk("R5 received byte", 32'(v), 32'h3C);
      rd(2'd1, v); chk("R6 data access alone keeps collision", 32'(v), 32'hC0);
      rd(2'd2, v);
      rd(2'd1, v); chk("R6 collision cleared", 32'(v), 32'h00);
      wr(2'd0, 8'h00);

      // R3 select ignored in master mode
      wr(2'd0, 8'h07);
      ss_n_i = 1'b0;
      idle(6);
      rd(2'd0, v); chk("R3 control kept", 32'(v), 32'h07);
      chk("R3 no error request", 32'(irq_err), 32'd0);
      rd(2'd1, v); chk("R3 no fault flag", 32'(v), 32'h00);
      ss_n_i = 1'b1;
      wr(2'd0, 8'h00);

      // R2 / R4 mode fault
      wr(2'd0, 8'h03);
      ss_n_i = 1'b0;
      idle(6);
      chk("R2 error request", 32'(irq_err), 32'd1);
      rd(2'd0, v); chk("R2 enable and master cleared", 32'(v), 32'h00);
      ss_n_i = 1'b1;
      idle(4);
      wr(2'd0, 8'h00);
      chk("R4 control write alone keeps fault", 32'(irq_err), 32'd1);
      rd(2'd1, v); chk("R2 fault status bit", 32'(v), 32'h10);
      wr(2'd0, 8'h03);
      chk("R4 fault cleared", 32'(irq_err), 32'd0);
      rd(2'd0, v); chk("R4 enable restored", 32'(v), 32'h03);
      rd(2'd1, v); chk("R4 status clear", 32'(v), 32'h00);

      // R9 gating by select-ignore
      ss_n_i = 1'b0;
      idle(6);
      chk("R9 request with fault", 32'(irq_err), 32'd1);
      ss_n_i = 1'b1;
      idle(4);
      wr(2'd0, 8'h04);
      chk("R9 request gated by ignore bit", 32'(irq_err), 32'd0);
      rd(2'd1, v); chk("R9 fault flag stays", 32'(v), 32'h10);
      wr(2'd0, 8'h00);
      rd(2'd1, v); chk("R4 fault cleared after gating", 32'(v), 32'h00);

      // R13 slave sweep
      wr(2'd0, 8'h01);
      for (int i = 0; i < 8; i++) begin
         tx = 8'((i * 53 + 8'h0F) & 255);
         m  = 8'(((i * 19) ^ 8'h5C) & 255);
         wr(2'd2, tx);
         slave_xfer(m, 8, got);
         chk("R13 slave shifted out msb first", 32'(got), 32'(tx));
         chk("R13 finished request", 32'(irq_xfer), 32'd1);
         rd(2'd1, v); chk("R13 status finished", 32'(v), 32'h80);
         rd(2'd2, v); chk("R13 slave received byte", 32'(v), 32'(m));
      end

      // R7 / R8 early select release
      slave_xfer(8'h3C, 3, got);
      rd(2'd1, v); chk("R7 slave select error flag", 32'(v), 32'h20);
      chk("R7 no requests", {30'd0, irq_xfer, irq_err}, 32'd0);
      wr(2'd0, 8'h01);
      rd(2'd1, v); chk("R8 enable write keeps flag", 32'(v), 32'h20);
      wr(2'd0, 8'h00);
      rd(2'd1, v); chk("R8 flag cleared by disable", 32'(v), 32'h00);
      wr(2'd0, 8'h01);
      wr(2'd2, 8'h5A);
      slave_xfer(8'hC3, 8, got);
      chk("R8 next slave byte out", 32'(got), 32'h5A);
      rd(2'd1, v);
      rd(2'd2, v); chk("R8 next slave byte in", 32'(v), 32'hC3);
      wr(2'd0, 8'h00);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule